// File: doc/BRIEF.md
# I2C Slave with Clock Stretching

This block is a 7-bit-address I2C target that runs entirely on the system clock. The SCL and SDA pins reach it through a synchronizer chain. It drives each line only as an open-drain pull-down enable. It finds START and STOP conditions and compares the incoming address with a fixed parameter. It then receives bytes from the bus controller or sends bytes to it.

A single byte buffer is shared by both directions. It has a full flag, a sticky overflow flag, a read/write status bit copied from the address byte, and an interrupt flag that is raised once per byte. In the read direction the target holds SCL low after every acknowledged byte. It keeps doing so until the host has written the next byte and set a clock-release bit.

The host side uses single-cycle strobes. One reads the buffer, one writes it, one clears the interrupt, one clears the overflow flag, and one releases the clock.

Top module: `i2c_stretch_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts address reception from any state. A rising SDA while SCL is high (STOP) returns the target to idle.
- R2: When the first seven received bits, sent MSB first, equal SLAVE_ADDR, the target pulls SDA low for the ninth clock. The whole address byte goes into the buffer, `buf_full` sets, and `rw_stat` takes bit 0 of that byte (1 = read). A mismatching address gets no ACK and leaves every flag unchanged.
- R3: While `buf_full` or `overflow` is set, the target does not ACK a completed byte and does not overwrite the buffer. A byte that completes while `buf_full` is set sets `overflow`.
- R4: `irq` sets on the falling edge of the ninth SCL pulse of every byte handled after an address match. Only `host_clr_irq` clears it.
- R5: `host_rd` clears `buf_full`. `overflow` stays set until `host_clr_ovf`.
- R6: After a matching read address is ACKed, the target holds SCL low and `clk_rel` reads 0.
- R7: `host_release` sets `clk_rel` only if the buffer has been written since the stretch began. Otherwise it has no effect and SCL stays held.
- R8: In the read direction, bits go out MSB first. SDA changes only after SCL falls, so SDA is stable while SCL is high.
- R9: The controller's ninth-bit level is sampled on the rising SCL edge. Low (ACK) leads to another stretch with `clk_rel` cleared. High (NACK) clears `rw_stat`, and the target ignores the bus until the next START.
- R10: In the write direction, each received data byte is placed in the buffer and ACKed when the buffer is empty and no overflow is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| host_wr | input | 1 | Write strobe for the buffer and transmit shifter |
| host_wdata | input | 8 | Byte to write |
| host_rd | input | 1 | Read strobe; clears the full flag |
| host_rdata | output | 8 | Current buffer contents |
| host_clr_irq | input | 1 | Clears the interrupt flag |
| host_clr_ovf | input | 1 | Clears the overflow flag |
| host_release | input | 1 | Requests release of a stretched SCL |
| buf_full | output | 1 | Buffer holds an unread received byte |
| overflow | output | 1 | A byte arrived while the buffer was full |
| rw_stat | output | 1 | Direction of the current transfer, 1 = read |
| irq | output | 1 | Per-byte interrupt flag |
| clk_rel | output | 1 | Clock-release bit |

## Verification
A change on a bus line passes through two synchronizer stages and reaches the edge detectors on the second clock edge. The engine acts on the third edge, and any flag or pull-down enable it updates is visible after that edge. The bench holds every SCL phase for 12 clocks and samples bus and flag values in the middle of a phase or a full phase later. Its results therefore never depend on the three-cycle pipeline. Host strobes last one cycle from a falling clock edge, and their effects are read at the next falling edge. That is the first point after the single register that holds them.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK9,
        ST_STRETCH,
        ST_TX,
        ST_TXACK
    } eng_st_t;

    // conditioned bus events in the system clock domain
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_t;

    // one-cycle requests from the bus engine to the status registers
    typedef struct packed {
        logic              load;
        logic [BYTE_W-1:0] data;
        logic              rw_set;
        logic              rw_val;
        logic              ovf_set;
        logic              irq_set;
        logic              rel_clr;
        logic              status_rst;
    } evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] a);
        return b[BYTE_W-1:1] == a;
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  scl_i,
    input  logic  sda_i,
    output line_t line_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sh, sda_sh;
    logic         scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[TOP-1:0], scl_i};
            sda_sh <= {sda_sh[TOP-1:0], sda_i};
            scl_d  <= scl_sh[TOP];
            sda_d  <= sda_sh[TOP];
        end
    end

    always_comb begin
        line_o.sda      = sda_sh[TOP];
        line_o.scl_rise = scl_sh[TOP] & ~scl_d;
        line_o.scl_fall = ~scl_sh[TOP] & scl_d;
        line_o.start    = scl_sh[TOP] & scl_d & sda_d & ~sda_sh[TOP];
        line_o.stop     = scl_sh[TOP] & scl_d & ~sda_d & sda_sh[TOP];
    end

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h3A
) (
    input  logic              clk,
    input  logic              rst,
    input  line_t             ln,
    input  logic              blocked_i,
    input  logic              full_i,
    input  logic              clk_rel_i,
    input  logic              tx_load_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    output evt_t              ev,
    output logic              scl_oe,
    output logic              sda_oe
);
    eng_st_t           st_q, st_n;
    logic [BYTE_W-1:0] rxsh_q, rxsh_n, txsh_q, txsh_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              is_addr_q, is_addr_n, rd_q, rd_n, ack_q, ack_n, mnack_q, mnack_n;
    logic              ack_drv;

    always_comb begin
        st_n      = st_q;
        rxsh_n    = rxsh_q;
        txsh_n    = txsh_q;
        cnt_n     = cnt_q;
        is_addr_n = is_addr_q;
        rd_n      = rd_q;
        ack_n     = ack_q;
        mnack_n   = mnack_q;
        ev        = '0;

        if (tx_load_i && st_q != ST_TX && st_q != ST_TXACK)
            txsh_n = tx_data_i;

        if (ln.start) begin
            st_n      = ST_RECV;
            cnt_n     = '0;
            is_addr_n = 1'b1;
        end else if (ln.stop) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_RECV: begin
                    if (ln.scl_rise && cnt_q < CNT_W'(BYTE_W)) begin
                        rxsh_n = {rxsh_q[BYTE_W-2:0], ln.sda};
                        cnt_n  = cnt_q + 1'b1;
                    end else if (ln.scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                        if (is_addr_q && !addr_hit(rxsh_q, SLAVE_ADDR)) begin
                            st_n = ST_IDLE;
                        end else begin
                            st_n       = ST_ACK9;
                            ack_n      = !blocked_i;
                            ev.ovf_set = full_i;
                            if (!blocked_i) begin
                                ev.load = 1'b1;
                                ev.data = rxsh_q;
                            end
                            if (is_addr_q) begin
                                rd_n = rxsh_q[0] & !blocked_i;
                                if (!blocked_i) begin
                                    ev.rw_set = 1'b1;
                                    ev.rw_val = rxsh_q[0];
                                end
                            end
                        end
                    end
                end
                ST_ACK9: begin
                    if (ln.scl_fall) begin
                        ev.irq_set = 1'b1;
                        cnt_n      = '0;
                        is_addr_n  = 1'b0;
                        if (rd_q && ack_q) begin
                            st_n       = ST_STRETCH;
                            ev.rel_clr = 1'b1;
                        end else begin
                            st_n = rd_q ? ST_IDLE : ST_RECV;
                        end
                    end
                end
                ST_STRETCH: begin
                    if (clk_rel_i) begin
                        st_n  = ST_TX;
                        cnt_n = '0;
                    end
                end
                ST_TX: begin
                    if (ln.scl_rise) begin
                        cnt_n = cnt_q + 1'b1;
                    end else if (ln.scl_fall) begin
                        if (cnt_q == CNT_W'(BYTE_W)) st_n = ST_TXACK;
                        else txsh_n = {txsh_q[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_TXACK: begin
                    if (ln.scl_rise) begin
                        mnack_n = ln.sda;
                    end else if (ln.scl_fall) begin
                        ev.irq_set = 1'b1;
                        if (mnack_q) begin
                            st_n          = ST_IDLE;
                            rd_n          = 1'b0;
                            ev.status_rst = 1'b1;
                        end else begin
                            st_n       = ST_STRETCH;
                            ev.rel_clr = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            rxsh_q    <= '0;
            txsh_q    <= '0;
            cnt_q     <= '0;
            is_addr_q <= 1'b0;
            rd_q      <= 1'b0;
            ack_q     <= 1'b0;
            mnack_q   <= 1'b0;
        end else begin
            st_q      <= st_n;
            rxsh_q    <= rxsh_n;
            txsh_q    <= txsh_n;
            cnt_q     <= cnt_n;
            is_addr_q <= is_addr_n;
            rd_q      <= rd_n;
            ack_q     <= ack_n;
            mnack_q   <= mnack_n;
        end
    end

    assign ack_drv = (st_q == ST_ACK9) && ack_q;
    assign scl_oe  = (st_q == ST_STRETCH) && !clk_rel_i;
    assign sda_oe  = ack_drv || ((st_q == ST_TX) && !txsh_q[BYTE_W-1]);

    AST_NACK_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_drv) |-> $past(!blocked_i)); // R3

    AST_TX_SDA_STEADY: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TX && $past(st_q) == ST_TX && !$past(ln.scl_fall)) |-> $stable(sda_oe)); // R8

    AST_STRETCH_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        scl_oe |-> rd_q); // R6

endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
    import i2cs_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h3A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    input  logic        host_rd,
    output logic [7:0]  host_rdata,
    input  logic        host_clr_irq,
    input  logic        host_clr_ovf,
    input  logic        host_release,
    output logic        buf_full,
    output logic        overflow,
    output logic        rw_stat,
    output logic        irq,
    output logic        clk_rel
);
    line_t             ln;
    evt_t              ev;
    logic [BYTE_W-1:0] buf_q;
    logic              full_q, ovf_q, rw_q, irq_q, rel_q, txl_q;

    i2cs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .line_o (ln)
    );

    i2cs_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .ln        (ln),
        .blocked_i (full_q | ovf_q),
        .full_i    (full_q),
        .clk_rel_i (rel_q),
        .tx_load_i (host_wr),
        .tx_data_i (host_wdata),
        .ev        (ev),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            full_q <= 1'b0;
            ovf_q  <= 1'b0;
            rw_q   <= 1'b0;
            irq_q  <= 1'b0;
            rel_q  <= 1'b0;
            txl_q  <= 1'b0;
        end else begin
            if (host_wr) buf_q <= host_wdata;
            if (ev.load) begin
                buf_q  <= ev.data;
                full_q <= 1'b1;
            end else if (host_rd) begin
                full_q <= 1'b0;
            end

            if (ev.ovf_set)         ovf_q <= 1'b1;
            else if (host_clr_ovf)  ovf_q <= 1'b0;

            if (ev.status_rst)      rw_q <= 1'b0;
            else if (ev.rw_set)     rw_q <= ev.rw_val;

            if (ev.irq_set)         irq_q <= 1'b1;
            else if (host_clr_irq)  irq_q <= 1'b0;

            if (ev.rel_clr || ev.status_rst) txl_q <= 1'b0;
            else if (host_wr)                txl_q <= 1'b1;

            if (ev.rel_clr)                   rel_q <= 1'b0;
            else if (host_release && txl_q)   rel_q <= 1'b1;
        end
    end

    assign host_rdata = buf_q;
    assign buf_full   = full_q;
    assign overflow   = ovf_q;
    assign rw_stat    = rw_q;
    assign irq        = irq_q;
    assign clk_rel    = rel_q;

    AST_REL_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(rel_q) |-> $past(txl_q)); // R7

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !host_clr_irq) |=> irq_q); // R4

    AST_OVF_HELD: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !host_clr_ovf) |=> ovf_q); // R5

    AST_BUF_FROZEN_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (full_q && !host_rd && !host_wr) |=> $stable(buf_q)); // R3

endmodule

// File: tb/sim_i2c_stretch_slave.sv
module sim_i2c_stretch_slave;

    localparam int H = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, scl_w, sda_w;
    logic host_wr = 0, host_rd = 0, host_clr_irq = 0, host_clr_ovf = 0, host_release = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic buf_full, overflow, rw_stat, irq, clk_rel;

    assign scl_w = scl_m & ~scl_oe;
    assign sda_w = sda_m & ~sda_oe;

    i2c_stretch_slave #(.SLAVE_ADDR(7'h3A)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl_w), .sda_i(sda_w),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_clr_irq(host_clr_irq),
        .host_clr_ovf(host_clr_ovf), .host_release(host_release),
        .buf_full(buf_full), .overflow(overflow), .rw_stat(rw_stat),
        .irq(irq), .clk_rel(clk_rel)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up;
        scl_m = 1'b1;
        @(negedge clk);
        while (scl_w == 1'b0) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_n(H);
        scl_up; wait_n(H);
        sda_m = 1'b0; wait_n(H);
        scl_m = 1'b0; wait_n(H);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_n(H);
        scl_up; wait_n(H);
        sda_m = 1'b1; wait_n(H);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_n(H);
            scl_up; wait_n(H);
            scl_m = 1'b0; wait_n(H);
        end
        sda_m = 1'b1; wait_n(H);
        scl_up; wait_n(H/2);
        ack = !sda_w;
        wait_n(H/2);
        scl_m = 1'b0; wait_n(H);
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] b, output logic steady);
        logic first;
        steady = 1'b1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_n(H);
            scl_up;
            first = sda_w;
            wait_n(H);
            b[i] = sda_w;
            if (first !== sda_w) steady = 1'b0;
            scl_m = 1'b0;
        end
        wait_n(H/2);
        sda_m = nack; wait_n(H/2);
        scl_up; wait_n(H);
        scl_m = 1'b0; wait_n(H);
        sda_m = 1'b1;
    endtask

    task automatic host_pulse(input int which, input logic [7:0] d);
        @(negedge clk);
        host_wdata = d;
        case (which)
            0: host_wr = 1'b1;
            1: host_rd = 1'b1;
            2: host_clr_irq = 1'b1;
            3: host_clr_ovf = 1'b1;
            default: host_release = 1'b1;
        endcase
        @(negedge clk);
        host_wr = 0; host_rd = 0; host_clr_irq = 0; host_clr_ovf = 0; host_release = 0;
    endtask

    // {address byte, data byte, expected address ACK}
    localparam logic [16:0] VEC [4] = '{
        {8'h74, 8'h5C, 1'b1},
        {8'h76, 8'h11, 1'b0},
        {8'h74, 8'hA3, 1'b1},
        {8'h20, 8'hFF, 1'b0}
    };

    initial begin
        logic ack, steady;
        logic [7:0] rb;
        wait_n(5);
        rst = 1'b0;
        wait_n(3);
        check("R1 reset scl_oe", scl_oe, 0);
        check("R1 reset sda_oe", sda_oe, 0);
        check("R4 reset irq", irq, 0);
        check("R5 reset full/ovf", {buf_full, overflow}, 0);

        foreach (VEC[k]) begin
            bus_start;
            write_byte(VEC[k][16:9], ack);
            check("R2 address ACK", ack, VEC[k][0]);
            if (VEC[k][0]) begin
                check("R2 buffer holds address", host_rdata, VEC[k][16:9]);
                check("R2 full and rw", {buf_full, rw_stat}, 2'b10);
                check("R4 irq after address", irq, 1);
                host_pulse(1, 0);
                check("R5 read clears full", buf_full, 0);
                host_pulse(2, 0);
                write_byte(VEC[k][8:1], ack);
                check("R10 data ACK", ack, 1);
                check("R10 data in buffer", host_rdata, VEC[k][8:1]);
                bus_stop;
                check("R4 irq held until cleared", irq, 1);
                host_pulse(1, 0);
                host_pulse(2, 0);
                check("R4 irq cleared by host", irq, 0);
            end else begin
                check("R2 mismatch leaves flags", {irq, buf_full, rw_stat}, 0);
                bus_stop;
            end
        end

        // overflow: address left unread, data byte arrives
        bus_start;
        write_byte(8'h74, ack);
        check("R2 address ACK before overflow", ack, 1);
        write_byte(8'h99, ack);
        check("R3 no ACK while full", ack, 0);
        check("R3 overflow set", overflow, 1);
        check("R3 buffer not overwritten", host_rdata, 8'h74);
        bus_stop;
        host_pulse(1, 0);
        check("R5 overflow survives read", {buf_full, overflow}, 2'b01);
        bus_start;
        write_byte(8'h74, ack);
        check("R3 address NACK while overflow", ack, 0);
        bus_stop;
        host_pulse(3, 0);
        host_pulse(2, 0);
        check("R5 overflow cleared by host", overflow, 0);

        // repeated START restarts address phase
        bus_start;
        write_byte(8'h74, ack);
        host_pulse(1, 0);
        bus_start;
        write_byte(8'h74, ack);
        check("R1 repeated START address ACK", ack, 1);
        bus_stop;
        host_pulse(1, 0);
        host_pulse(2, 0);

        // read direction with stretching
        bus_start;
        write_byte(8'h75, ack);
        check("R2 read address ACK", ack, 1);
        check("R2 rw set", rw_stat, 1);
        wait_n(20);
        check("R6 scl held low", {scl_oe, scl_w}, 2'b10);
        check("R6 clk_rel clear", clk_rel, 0);
        host_pulse(1, 0);
        host_pulse(2, 0);
        host_pulse(4, 0);
        wait_n(10);
        check("R7 release ignored before write", {scl_oe, clk_rel}, 2'b10);
        host_pulse(0, 8'hC6);
        host_pulse(4, 0);
        check("R7 release after write", {scl_oe, clk_rel}, 2'b01);
        read_byte(1'b0, rb, steady);
        check("R8 transmitted byte", rb, 8'hC6);
        check("R8 sda steady while scl high", steady, 1);
        check("R4 irq after sent byte", irq, 1);
        check("R9 ACK leads to new stretch", {scl_oe, clk_rel}, 2'b10);
        host_pulse(2, 0);
        host_pulse(0, 8'h39);
        host_pulse(4, 0);
        read_byte(1'b1, rb, steady);
        check("R8 second transmitted byte", rb, 8'h39);
        check("R9 NACK clears rw, no stretch", {rw_stat, scl_oe}, 0);
        host_pulse(2, 0);
        write_byte(8'h74, ack);
        check("R9 bus ignored until START", {ack, irq}, 0);
        bus_stop;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule